// File: doc/BRIEF.md
# Character-Clock Raster Timing Generator

This block produces the horizontal and vertical raster timing for a display controller that counts in character cells of 8 pixels. It is clocked once per character. A horizontal counter steps through the characters of a line. A vertical counter steps through the lines of a frame. From these two counters and a set of programmed limits, the block drives the sync pulses, the blanking flags, a display-enable, a one-cycle line-match interrupt and a retrace status bit.

The limits are held in a small write-only register file, and several of them use an offset encoding. The horizontal total field holds the character count minus 5, and the vertical total holds the line count minus 2. The horizontal and vertical display-end fields hold the last active position, which is the count minus 1. The vertical sync start field holds its start line minus 1.

The end fields are short and are compared only with the low bits of the matching counter. This caps each pulse: horizontal sync lasts at most 32 characters, and vertical sync at most 16 lines. Timing fields are captured in a shadow copy and go live together at the first position of a new frame. The output-control field acts at once, so that software can blank the picture or stop the syncs for power saving.

Top module: `crtc_timing`

## Requirements
- R1: While reset is held, and until the first clock after it is released, both counters are 0 and all four internal sync and blank flags are clear. The registers read as 0, except line-compare, which reads as all ones. In this state hsync_o, vsync_o, hblank_o, vblank_o, lc_irq_o and vretrace_o are 0 and de_o is 1.
- R2: The character counter runs from 0 to (htotal field + 4) and then returns to 0. The line counter advances by one only on the clock where the character counter returns to 0, and it runs from 0 to (vtotal field + 1).
- R3: de_o is 1 exactly when the character count is at most the horizontal display-end field, the line count is at most the vertical display-end field, and control bit 4 (display off) is 0.
- R4: The horizontal blank flag sets when the character count equals the blank-start field. It clears when the low 7 bits of the count equal the 7-bit blank-end field. The vertical blank flag follows the same rule with its start field and an 8-bit end field matched against the low 8 bits of the line count, and it is updated only when a new line starts. A start match wins over an end match in the same position.
- R5: The horizontal sync flag sets when the character count equals the sync-start field and clears when the low 5 bits of the count equal the 5-bit sync-end field, with start winning over end.
- R6: The vertical sync flag is updated only when a new line starts. It sets on line (vsync-start field + 1), taken modulo 2^12, and clears when the low 4 bits of the line count equal the 4-bit sync-end field, with start winning over end.
- R7: Control bit 0 sets the hsync_o polarity and control bit 1 sets the vsync_o polarity. When the bit is 1 the output is active-low; when it is 0 the output is active-high.
- R8: Control bit 2 holds hsync_o at its inactive level, and control bit 3 holds vsync_o at its inactive level. The inactive level equals the polarity bit.
- R9: lc_irq_o is 1 for exactly the one cycle in which the character count is 0 and the line count equals the line-compare field.
- R10: vretrace_o equals the internal vertical sync flag, whatever the polarity and disable bits are set to.
- R11: Writes to timing fields go to a shadow copy. The shadow copy is made live on the clock edge where both counters return to 0, and the new values govern that first position. A write on the same edge lands in the following frame. Writes to the control field act from the next clock.
- R12: Register addresses and widths are: 0 htotal (10 bits), 1 hdisplay-end (10), 2 hblank-start (10), 3 hblank-end (7), 4 hsync-start (10), 5 hsync-end (5), 6 vtotal (12), 7 vdisplay-end (12), 8 vblank-start (12), 9 vblank-end (8), 10 vsync-start (12), 11 vsync-end (4), 12 line-compare (12), 13 control (5). Upper data bits are dropped. Writes to addresses 14 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity and disable |
| vsync_o | output | 1 | Vertical sync after polarity and disable |
| hblank_o | output | 1 | Horizontal blank flag |
| vblank_o | output | 1 | Vertical blank flag |
| de_o | output | 1 | Display enable |
| lc_irq_o | output | 1 | One-cycle line-compare pulse |
| vretrace_o | output | 1 | Vertical retrace in progress |

## Verification
Two functions can fall on the same clock edge: a software write to a timing field, and the frame-boundary commit of the shadow copy into the live set. Whether such a write lands in this frame or the next depends on the order of those two actions.

The bench provokes this collision in two ways. It writes registers at random times, some of which fall on the last character of a frame. It also writes the line total part-way through a frame and measures the spacing of the line-compare pulses that follow. The spacing that spans the write must keep the old frame length, and only the next spacing may show the new one. A per-cycle reference model judges every output, including those on the boundary edges.

// File: rtl/crtc_timing.sv
module crtc_timing #(
  parameter int HW = 10,
  parameter int VW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [VW-1:0] wr_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          de_o,
  output logic          lc_irq_o,
  output logic          vretrace_o
);

  localparam int HBE_W  = 7;
  localparam int HSE_W  = 5;
  localparam int VBE_W  = 8;
  localparam int VSE_W  = 4;
  localparam int CTRL_W = 5;

  localparam logic [AW-1:0] A_HTOT = AW'(0);
  localparam logic [AW-1:0] A_HDE  = AW'(1);
  localparam logic [AW-1:0] A_HBS  = AW'(2);
  localparam logic [AW-1:0] A_HBE  = AW'(3);
  localparam logic [AW-1:0] A_HSS  = AW'(4);
  localparam logic [AW-1:0] A_HSE  = AW'(5);
  localparam logic [AW-1:0] A_VTOT = AW'(6);
  localparam logic [AW-1:0] A_VDE  = AW'(7);
  localparam logic [AW-1:0] A_VBS  = AW'(8);
  localparam logic [AW-1:0] A_VBE  = AW'(9);
  localparam logic [AW-1:0] A_VSS  = AW'(10);
  localparam logic [AW-1:0] A_VSE  = AW'(11);
  localparam logic [AW-1:0] A_LC   = AW'(12);
  localparam logic [AW-1:0] A_CTRL = AW'(13);

  logic [HW-1:0]     s_htot, s_hde, s_hbs, s_hss;
  logic [HBE_W-1:0]  s_hbe;
  logic [HSE_W-1:0]  s_hse;
  logic [VW-1:0]     s_vtot, s_vde, s_vbs, s_vss, s_lc;
  logic [VBE_W-1:0]  s_vbe;
  logic [VSE_W-1:0]  s_vse;

  logic [HW-1:0]     a_htot, a_hde, a_hbs, a_hss;
  logic [HBE_W-1:0]  a_hbe;
  logic [HSE_W-1:0]  a_hse;
  logic [VW-1:0]     a_vtot, a_vde, a_vbs, a_vss, a_lc;
  logic [VBE_W-1:0]  a_vbe;
  logic [VSE_W-1:0]  a_vse;

  logic [CTRL_W-1:0] ctrl;

  logic [HW-1:0] hcnt, hcnt_n;
  logic [VW-1:0] vcnt, vcnt_n;
  logic hblank_q, hsync_q, vblank_q, vsync_q;
  logic hblank_n, hsync_n, vblank_n, vsync_n;
  logic hlast, vlast, frame_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_htot <= '0; s_hde <= '0; s_hbs <= '0; s_hbe <= '0; s_hss <= '0; s_hse <= '0;
      s_vtot <= '0; s_vde <= '0; s_vbs <= '0; s_vbe <= '0; s_vss <= '0; s_vse <= '0;
      s_lc   <= '1;
      ctrl   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_HTOT:  s_htot <= wr_data[HW-1:0];
        A_HDE:   s_hde  <= wr_data[HW-1:0];
        A_HBS:   s_hbs  <= wr_data[HW-1:0];
        A_HBE:   s_hbe  <= wr_data[HBE_W-1:0];
        A_HSS:   s_hss  <= wr_data[HW-1:0];
        A_HSE:   s_hse  <= wr_data[HSE_W-1:0];
        A_VTOT:  s_vtot <= wr_data;
        A_VDE:   s_vde  <= wr_data;
        A_VBS:   s_vbs  <= wr_data;
        A_VBE:   s_vbe  <= wr_data[VBE_W-1:0];
        A_VSS:   s_vss  <= wr_data;
        A_VSE:   s_vse  <= wr_data[VSE_W-1:0];
        A_LC:    s_lc   <= wr_data;
        A_CTRL:  ctrl   <= wr_data[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  logic [HW:0] h_end;
  logic [VW:0] v_end;
  assign h_end = {1'b0, a_htot} + (HW+1)'(4);
  assign v_end = {1'b0, a_vtot} + (VW+1)'(1);
  assign hlast = ({1'b0, hcnt} == h_end);
  assign vlast = ({1'b0, vcnt} == v_end);
  assign frame_wrap = hlast && vlast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_htot <= '0; a_hde <= '0; a_hbs <= '0; a_hbe <= '0; a_hss <= '0; a_hse <= '0;
      a_vtot <= '0; a_vde <= '0; a_vbs <= '0; a_vbe <= '0; a_vss <= '0; a_vse <= '0;
      a_lc   <= '1;
    end else if (frame_wrap) begin
      a_htot <= s_htot; a_hde <= s_hde; a_hbs <= s_hbs; a_hbe <= s_hbe;
      a_hss  <= s_hss;  a_hse <= s_hse;
      a_vtot <= s_vtot; a_vde <= s_vde; a_vbs <= s_vbs; a_vbe <= s_vbe;
      a_vss  <= s_vss;  a_vse <= s_vse; a_lc  <= s_lc;
    end
  end

  logic [HW-1:0]    n_hbs, n_hss;
  logic [HBE_W-1:0] n_hbe;
  logic [HSE_W-1:0] n_hse;
  logic [VW-1:0]    n_vbs, n_vss, vs_line;
  logic [VBE_W-1:0] n_vbe;
  logic [VSE_W-1:0] n_vse;

  assign n_hbs = frame_wrap ? s_hbs : a_hbs;
  assign n_hbe = frame_wrap ? s_hbe : a_hbe;
  assign n_hss = frame_wrap ? s_hss : a_hss;
  assign n_hse = frame_wrap ? s_hse : a_hse;
  assign n_vbs = frame_wrap ? s_vbs : a_vbs;
  assign n_vbe = frame_wrap ? s_vbe : a_vbe;
  assign n_vss = frame_wrap ? s_vss : a_vss;
  assign n_vse = frame_wrap ? s_vse : a_vse;
  assign vs_line = n_vss + VW'(1);

  assign hcnt_n = hlast ? '0 : hcnt + 1'b1;
  assign vcnt_n = !hlast ? vcnt : (vlast ? '0 : vcnt + 1'b1);

  assign hblank_n = (hcnt_n == n_hbs) || (hblank_q && (hcnt_n[HBE_W-1:0] != n_hbe));
  assign hsync_n  = (hcnt_n == n_hss) || (hsync_q  && (hcnt_n[HSE_W-1:0] != n_hse));
  assign vblank_n = (vcnt_n == n_vbs) || (vblank_q && (vcnt_n[VBE_W-1:0] != n_vbe));
  assign vsync_n  = (vcnt_n == vs_line) || (vsync_q && (vcnt_n[VSE_W-1:0] != n_vse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; vcnt <= '0;
      hblank_q <= 1'b0; hsync_q <= 1'b0; vblank_q <= 1'b0; vsync_q <= 1'b0;
    end else begin
      hcnt     <= hcnt_n;
      vcnt     <= vcnt_n;
      hblank_q <= hblank_n;
      hsync_q  <= hsync_n;
      if (hlast) begin
        vblank_q <= vblank_n;
        vsync_q  <= vsync_n;
      end
    end
  end

  assign hsync_o    = (hsync_q && !ctrl[2]) ^ ctrl[0];
  assign vsync_o    = (vsync_q && !ctrl[3]) ^ ctrl[1];
  assign hblank_o   = hblank_q;
  assign vblank_o   = vblank_q;
  assign de_o       = (hcnt <= a_hde) && (vcnt <= a_vde) && !ctrl[4];
  assign lc_irq_o   = (hcnt == '0) && (vcnt == a_lc);
  assign vretrace_o = vsync_q;

  // R2
  hwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlast |=> (hcnt == '0));

  // R2
  vhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hlast |=> $stable(vcnt));

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_irq_o |=> !lc_irq_o);

  // R11
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable({a_htot, a_hde, a_hbs, a_hbe, a_hss, a_hse,
                             a_vtot, a_vde, a_vbs, a_vbe, a_vss, a_vse, a_lc}));

  // R6
  vs_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vretrace_o) |-> (hcnt == '0));

endmodule

// File: tb/sim_crtc_timing.sv
module sim_crtc_timing;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wr_en;
  logic [3:0]  wr_addr;
  logic [11:0] wr_data;
  logic hsync_o, vsync_o, hblank_o, vblank_o, de_o, lc_irq_o, vretrace_o;

  crtc_timing u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o), .vblank_o(vblank_o),
    .de_o(de_o), .lc_irq_o(lc_irq_o), .vretrace_o(vretrace_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit chk_en = 0, done = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int fm(input int a);
    case (a)
      0, 1, 2, 4:      return 1023;
      3:               return 127;
      5:               return 31;
      9:               return 255;
      11:              return 15;
      13:              return 31;
      6, 7, 8, 10, 12: return 4095;
      default:         return 0;
    endcase
  endfunction

  int sh[14], ac[14];
  int mc, mh, mv;
  bit fhb, fhs, fvb, fvs;

  always @(posedge clk) begin
    int nh, nv;
    bit hw, vw;
    if (!rst_n) begin
      for (int i = 0; i < 14; i++) begin sh[i] = 0; ac[i] = 0; end
      sh[12] = 4095; ac[12] = 4095;
      mc = 0; mh = 0; mv = 0;
      fhb = 0; fhs = 0; fvb = 0; fvs = 0;
    end else begin
      hw = (mh == ac[0] + 4);
      vw = (mv == ac[6] + 1);
      nh = hw ? 0 : mh + 1;
      nv = hw ? (vw ? 0 : mv + 1) : mv;
      if (hw && vw) for (int i = 0; i < 13; i++) ac[i] = sh[i];
      if (wr_en) begin
        if (wr_addr < 13) sh[wr_addr] = int'(wr_data) & fm(int'(wr_addr));
        else if (wr_addr == 13) mc = int'(wr_data) & 31;
      end
      if (nh == ac[2]) fhb = 1; else if ((nh & 127) == ac[3]) fhb = 0;
      if (nh == ac[4]) fhs = 1; else if ((nh & 31) == ac[5]) fhs = 0;
      if (hw) begin
        if (nv == ac[8]) fvb = 1; else if ((nv & 255) == ac[9]) fvb = 0;
        if (nv == ((ac[10] + 1) & 4095)) fvs = 1; else if ((nv & 15) == ac[11]) fvs = 0;
      end
      mh = nh; mv = nv;
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      chk("R5 R7 R8 hsync", hsync_o, (fhs & !mc[2]) ^ mc[0]);
      chk("R6 R7 R8 vsync", vsync_o, (fvs & !mc[3]) ^ mc[1]);
      chk("R4 hblank", hblank_o, fhb);
      chk("R4 vblank", vblank_o, fvb);
      chk("R3 de", de_o, (mh <= ac[1]) && (mv <= ac[7]) && !mc[4]);
      chk("R9 irq", lc_irq_o, (mh == 0) && (mv == ac[12]));
      chk("R10 retrace", vretrace_o, fvs);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog got=%0d exp=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = 12'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic prog(input int v[13]);
    for (int i = 0; i < 13; i++) wr(i, v[i]);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (lc_irq_o !== 1'b1);
  endtask

  task automatic hs_len(output int n);
    n = 0;
    while (hsync_o !== 1'b0) @(negedge clk);
    while (hsync_o !== 1'b1) @(negedge clk);
    while (hsync_o === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic vr_len(output int n);
    n = 0;
    while (vretrace_o !== 1'b0) @(negedge clk);
    while (vretrace_o !== 1'b1) @(negedge clk);
    while (vretrace_o === 1'b1) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n, m;
    int v[13];
    void'($urandom(1234));
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hsync", hsync_o, 0);
    chk("R1 vsync", vsync_o, 0);
    chk("R1 hblank", hblank_o, 0);
    chk("R1 vblank", vblank_o, 0);
    chk("R1 de", de_o, 1);
    chk("R1 irq", lc_irq_o, 0);
    chk("R1 retrace", vretrace_o, 0);
    rst_n = 1;
    chk_en = 1;

    // R2 R9: 8 chars x 4 lines
    v = '{3, 5, 6, 0, 6, 7, 2, 1, 2, 0, 1, 3, 0};
    prog(v);
    wait_irq(n);
    wait_irq(n);
    chk("R2 R9 frame length", n, 32);

    // R11: write htotal mid-frame, takes effect one frame later
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    wr(0, 7); n += 2;
    wait_irq(m); n += m;
    chk("R11 frame with pending write", n, 32);
    wait_irq(n);
    chk("R11 frame after commit", n, 48);

    // R12: unused addresses have no effect
    wr(14, 0); wr(15, 0);
    wait_irq(n);
    wait_irq(n);
    chk("R12 unused address ignored", n, 48);

    // R5 R6: 45 chars x 8 lines
    v = '{40, 30, 35, 40, 2, 7, 6, 4, 5, 7, 1, 5, 0};
    prog(v);
    wait_irq(n); wait_irq(n);
    hs_len(n);
    chk("R5 hsync length", n, 5);
    vr_len(n);
    chk("R6 vsync length", n, 135);
    wr(5, 2);
    wait_irq(n); wait_irq(n);
    hs_len(n);
    chk("R5 hsync max length", n, 32);

    // R7 R8: polarity and disable, checked per cycle by the model
    wr(13, 5'b00101);
    wait_irq(n); wait_irq(n);
    chk("R8 hsync held inactive", hsync_o, 1);
    wr(13, 5'b10010);
    wait_irq(n);
    chk("R3 display off de", de_o, 0);
    wr(13, 0);

    for (int k = 0; k < 12; k++) begin
      int ht, vt, chars, lines, a;
      ht = $urandom % 40; vt = $urandom % 30;
      chars = ht + 5; lines = vt + 2;
      v[0] = ht;                   v[1] = $urandom % (chars + 2);
      v[2] = $urandom % chars;     v[3] = $urandom % 128;
      v[4] = $urandom % chars;     v[5] = $urandom % 32;
      v[6] = vt;                   v[7] = $urandom % (lines + 1);
      v[8] = $urandom % lines;     v[9] = $urandom % 256;
      v[10] = $urandom % lines;    v[11] = $urandom % 16;
      v[12] = $urandom % (lines + 1);
      prog(v);
      wr(13, $urandom % 32);
      repeat (3 * chars * lines + 60) begin
        @(negedge clk);
        if ($urandom % 150 == 0) begin
          a = $urandom % 16;
          if (a == 0 || a == 6) a = 13;
          wr(a, $urandom % 4096);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule